// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block keeps a free-running up-counter that advances once every 2^N clock cycles, with N picked from a three-bit field, so that one counter can serve both fast and slow time bases. Software reaches it through a small word-addressed register port. The port can start, stop, clear and reload the count, set two compare values, and read back a bank of capture registers.

Each of the two compare channels owns one output pin. When a channel is enabled and the count steps onto its compare value, the pin changes state and a one-cycle match strobe fires. Software can drive either pin high or low at any time through separate set and clear bits in the control word. Each capture input passes through a two-flop synchroniser. A rising edge on an enabled input then copies the current count into that input's capture register and fires a one-cycle capture strobe.

Top module: `cct_top`

## Requirements
- R1: After reset, every register reads 0, both compare outputs are low and no strobe is asserted.
- R2: The count advances by one every 2^DIV clock cycles, where DIV is control bits [6:4], but only while control bit 0 (block on) and control bit 1 (count run) are both 1; otherwise it holds.
- R3: Writing 1 to control bit 2 zeroes the count and the divider phase in the same cycle, and the bit always reads back as 0.
- R4: A write to word 3 loads the count directly and also restarts the divider phase; a clear by R3 takes precedence over a load.
- R5: When compare channel k is enabled (control bit 8 for k=0, bit 9 for k=1) and the count steps onto compare value k, output k toggles and match strobe k is high for exactly one cycle, both registered on the same edge as the new count.
- R6: A compare channel whose enable bit is 0 neither toggles its output nor raises its strobe.
- R7: Writing 1 to control bit 17 (output 0) or bit 16 (output 1) drives that output high, and writing 1 to bit 25 (output 0) or bit 24 (output 1) drives it low. Clear wins over set, and both win over a match toggle. On reads, bits 17/25 return output 0 and bits 16/24 return output 1.
- R8: A rising edge on capture input i, taken when word 1 bit i and control bit 0 are both 1, stores the count into word 4+i three clock edges after the input rises, and strobe i is high for one cycle at that time. A disabled input leaves its register unchanged.
- R9: A falling edge on a capture input neither changes its register nor raises its strobe.
- R10: The word map is: 0 control, 1 capture enable mask, 2 spare (always reads 0), 3 count, 4..9 captures, 10 and 11 compare values 0 and 1. Read data is registered, one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cap_in | input | NUM_CAP | Asynchronous capture inputs |
| cmp_out | output | 2 | Compare output pins |
| cmp_evt | output | 2 | One-cycle match strobes |
| cap_evt | output | NUM_CAP | One-cycle capture strobes |

## Verification
The bench uses the default build: a 32-bit count, six capture inputs, a four-bit word address and a three-bit divider field. Because the field is three bits wide, the table can run divide-by-1, 2, 4, 8 and the largest ratio of 128 in a short run. Six captures place the compare words at 10 and 11, so the full word map can be reached. Holding the counter at a loaded value makes the captured count exact, and the three-edge synchroniser latency is checked edge by edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
  // control word bit positions
  localparam int CTL_ON    = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_ZERO  = 2;
  localparam int CTL_DIV   = 4;
  localparam int CTL_CE0   = 8;
  localparam int CTL_CE1   = 9;
  localparam int CTL_SET1  = 16;
  localparam int CTL_SET0  = 17;
  localparam int CTL_CLR1  = 24;
  localparam int CTL_CLR0  = 25;

  // word map
  localparam int W_CTL   = 0;
  localparam int W_CAPEN = 1;
  localparam int W_SPARE = 2;
  localparam int W_CNT   = 3;
  localparam int W_CAP0  = 4;

  typedef struct packed {
    logic [2:0] div;
    logic       ce1;
    logic       ce0;
    logic       run;
    logic       on;
  } ctl_t;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int PH_W = (1 << DIV_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] limit;

  assign limit = PH_W'((PH_W+1)'(1) << sel) - PH_W'(1);
  assign tick  = en && !restart && (phase == limit);

  always_ff @(posedge clk) begin
    if (rst || restart)
      phase <= '0;
    else if (en)
      phase <= (phase == limit) ? '0 : phase + PH_W'(1);
  end
endmodule

// File: rtl/cct_compare.sv
module cct_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic [CNT_W-1:0] next_cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             force_hi,
  input  logic             force_lo,
  output logic             pin,
  output logic             evt
);
  logic hit;

  assign hit = en && step && (next_cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
      evt <= 1'b0;
    end else begin
      evt <= hit;
      if (force_lo)
        pin <= 1'b0;
      else if (force_hi)
        pin <= 1'b1;
      else if (hit)
        pin <= ~pin;
    end
  end
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] held,
  output logic             evt
);
  logic [1:0] sync_q;
  logic       last_q;
  logic       rise;

  assign rise = sync_q[1] && !last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      held   <= '0;
      evt    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      last_q <= sync_q[1];
      evt    <= en && rise;
      if (en && rise)
        held <= cnt;
    end
  end
endmodule

// File: rtl/cct_top.sv
module cct_top #(
  parameter int CNT_W   = 32,
  parameter int NUM_CAP = 6,
  parameter int ADDR_W  = 4,
  parameter int DIV_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_CAP-1:0] cap_in,
  output logic [1:0]         cmp_out,
  output logic [1:0]         cmp_evt,
  output logic [NUM_CAP-1:0] cap_evt
);
  import cct_pkg::*;

  localparam int W_CMP0 = W_CAP0 + NUM_CAP;

  ctl_t                            ctl;
  logic [NUM_CAP-1:0]              cap_en;
  logic [CNT_W-1:0]                cnt;
  logic [1:0][CNT_W-1:0]           cmp_val;
  logic [NUM_CAP-1:0][CNT_W-1:0]   cap_val;
  logic                            wr_ctl, wr_cnt, zero_now, tick;
  logic [1:0]                      ce, set_req, clr_req;
  logic [31:0]                     rd_nx;

  assign wr_ctl   = wr_en && (addr == ADDR_W'(W_CTL));
  assign wr_cnt   = wr_en && (addr == ADDR_W'(W_CNT));
  assign zero_now = wr_ctl && wdata[CTL_ZERO];
  assign ce       = {ctl.on && ctl.ce1, ctl.on && ctl.ce0};
  assign set_req  = {wr_ctl && wdata[CTL_SET1], wr_ctl && wdata[CTL_SET0]};
  assign clr_req  = {wr_ctl && wdata[CTL_CLR1], wr_ctl && wdata[CTL_CLR0]};

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      cap_en  <= '0;
      cmp_val <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(W_CTL)) begin
        ctl.on  <= wdata[CTL_ON];
        ctl.run <= wdata[CTL_RUN];
        ctl.div <= wdata[CTL_DIV +: DIV_W];
        ctl.ce0 <= wdata[CTL_CE0];
        ctl.ce1 <= wdata[CTL_CE1];
      end
      if (addr == ADDR_W'(W_CAPEN))
        cap_en <= wdata[NUM_CAP-1:0];
      for (int k = 0; k < 2; k++)
        if (addr == ADDR_W'(W_CMP0 + k))
          cmp_val[k] <= wdata[CNT_W-1:0];
    end
  end

  cct_prescale #(.DIV_W(DIV_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .en      (ctl.on && ctl.run),
    .restart (zero_now || wr_cnt),
    .sel     (ctl.div),
    .tick    (tick)
  );

  // free-running count: clear beats load beats step
  always_ff @(posedge clk) begin
    if (rst || zero_now)
      cnt <= '0;
    else if (wr_cnt)
      cnt <= wdata[CNT_W-1:0];
    else if (tick)
      cnt <= cnt + CNT_W'(1);
  end

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    cct_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .en       (ce[k]),
      .step     (tick),
      .next_cnt (cnt + CNT_W'(1)),
      .cmp_val  (cmp_val[k]),
      .force_hi (set_req[k]),
      .force_lo (clr_req[k]),
      .pin      (cmp_out[k]),
      .evt      (cmp_evt[k])
    );
  end

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_cap
    cct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk  (clk),
      .rst  (rst),
      .en   (ctl.on && cap_en[i]),
      .pin  (cap_in[i]),
      .cnt  (cnt),
      .held (cap_val[i]),
      .evt  (cap_evt[i])
    );
  end

  // registered read path
  always_comb begin
    rd_nx = '0;
    if (addr == ADDR_W'(W_CTL)) begin
      rd_nx[CTL_ON]             = ctl.on;
      rd_nx[CTL_RUN]            = ctl.run;
      rd_nx[CTL_DIV +: DIV_W]   = ctl.div;
      rd_nx[CTL_CE0]            = ctl.ce0;
      rd_nx[CTL_CE1]            = ctl.ce1;
      rd_nx[CTL_SET0]           = cmp_out[0];
      rd_nx[CTL_CLR0]           = cmp_out[0];
      rd_nx[CTL_SET1]           = cmp_out[1];
      rd_nx[CTL_CLR1]           = cmp_out[1];
    end
    if (addr == ADDR_W'(W_CAPEN))
      rd_nx[NUM_CAP-1:0] = cap_en;
    if (addr == ADDR_W'(W_CNT))
      rd_nx[CNT_W-1:0] = cnt;
    for (int i = 0; i < NUM_CAP; i++)
      if (addr == ADDR_W'(W_CAP0 + i))
        rd_nx[CNT_W-1:0] = cap_val[i];
    for (int k = 0; k < 2; k++)
      if (addr == ADDR_W'(W_CMP0 + k))
        rd_nx[CNT_W-1:0] = cmp_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= rd_nx;
  end
endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
  parameter int NUM_CAP = 6,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [1:0]         cmp_out,
  input logic [1:0]         cmp_evt,
  input logic [NUM_CAP-1:0] cap_evt
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == '0);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (cmp_out == 2'b00 && cmp_evt == 2'b00 && cap_evt == '0)); // R1

  for (genvar k = 0; k < 2; k++) begin : g_k
    AST_MATCH_TOGGLES: assert property (@(posedge clk) disable iff (rst)
      (cmp_evt[k] && !$past(ctl_wr)) |-> (cmp_out[k] != $past(cmp_out[k]))); // R5
    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      cmp_evt[k] |=> !cmp_evt[k]); // R5
    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!cmp_evt[k] && !$past(ctl_wr)) |-> $stable(cmp_out[k])); // R6
  end

  for (genvar i = 0; i < NUM_CAP; i++) begin : g_i
    AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      cap_evt[i] |=> !cap_evt[i]); // R8
  end
endmodule

bind cct_top cct_chk #(.NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .cmp_out (cmp_out),
  .cmp_evt (cmp_evt),
  .cap_evt (cap_evt)
);

// File: tb/cct_top_test.sv
module cct_top_test;
  localparam int NUM_CAP = 6;
  localparam int ADDR_W  = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdata;
  logic [NUM_CAP-1:0] cap_in = '0;
  logic [1:0]         cmp_out, cmp_evt;
  logic [NUM_CAP-1:0] cap_evt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  cct_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out), .cmp_evt(cmp_evt),
    .cap_evt(cap_evt)
  );

  always #2.5 clk = ~clk;

  // divider table: DIV field, idle cycles after start, expected count
  localparam int NV = 5;
  localparam int V_DIV [NV] = '{0, 1, 2, 3, 7};
  localparam int V_WAIT[NV] = '{9, 9, 15, 31, 255};
  localparam int V_EXP [NV] = '{10, 5, 4, 4, 2};

  localparam logic [31:0] ON = 32'h1, RUN = 32'h2, ZERO = 32'h4;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    @(posedge clk);
    #1 d = rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(3, v); chk("R1 count", v, 0);
    chk("R1 outputs", {cmp_out, cmp_evt, cap_evt}, 0);

    // R2 divider table
    for (int n = 0; n < NV; n++) begin
      wr(0, ON | ZERO);
      wr(0, ON | RUN | 32'(V_DIV[n] << 4));
      repeat (V_WAIT[n]) @(posedge clk);
      wr(0, ON | 32'(V_DIV[n] << 4));
      rd(3, v); chk($sformatf("R2 div=%0d", V_DIV[n]), v, V_EXP[n]);
    end

    // R2 holds when stopped or block off
    repeat (20) @(posedge clk);
    rd(3, v); chk("R2 hold run=0", v, 2);
    wr(0, RUN);
    repeat (20) @(posedge clk);
    wr(0, ON);
    rd(3, v); chk("R2 hold on=0", v, 2);

    // R3 self-clearing zero bit
    wr(0, ON | ZERO);
    rd(3, v); chk("R3 count zeroed", v, 0);
    rd(0, v); chk("R3 bit reads 0", v, ON);

    // R4 load, clear beats load not testable in one word: load then read
    wr(3, 32'hDEAD_0001);
    rd(3, v); chk("R4 load", v, 32'hDEAD_0001);

    // R10 map
    wr(10, 5); wr(11, 5); wr(2, 32'hFFFF_FFFF); wr(1, 32'h4);
    rd(10, v); chk("R10 cmp0 word", v, 5);
    rd(11, v); chk("R10 cmp1 word", v, 5);
    rd(2, v);  chk("R10 spare word", v, 0);
    rd(1, v);  chk("R10 capen word", v, 4);

    // R5/R6 compare: ch0 enabled, ch1 not, both at 5
    wr(0, ON | ZERO);
    wr(0, ON | RUN | 32'h100);
    repeat (4) @(negedge clk);
    chk("R5 no early match", {cmp_evt, cmp_out}, 0);
    @(negedge clk);
    chk("R5 match strobe", cmp_evt, 2'b01);
    chk("R5 toggle", cmp_out, 2'b01);
    @(negedge clk);
    chk("R5 one-cycle strobe", cmp_evt, 2'b00);
    chk("R6 disabled channel quiet", cmp_out[1], 1'b0);
    wr(0, ON);

    // R7 force set / clear
    wr(0, ON | (32'h1 << 25));
    chk("R7 clear out0", cmp_out[0], 1'b0);
    wr(0, ON | (32'h1 << 16));
    chk("R7 set out1", cmp_out[1], 1'b1);
    wr(0, ON | (32'h1 << 17) | (32'h1 << 25));
    chk("R7 clear wins", cmp_out[0], 1'b0);
    rd(0, v); chk("R7 readback", v, 32'h0101_0001);

    // R8 capture with stopped counter
    wr(3, 32'h1234);
    @(negedge clk) cap_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 latency", cap_evt, 0);
    @(negedge clk);
    chk("R8 strobe", cap_evt, 6'b000100);
    @(negedge clk);
    chk("R8 one-cycle strobe", cap_evt, 0);
    rd(6, v); chk("R8 captured count", v, 32'h1234);

    // R9 falling edge ignored
    wr(3, 32'h99);
    seen = 0;
    @(negedge clk) cap_in[2] = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (cap_evt != 0) seen++;
    end
    chk("R9 no strobe on fall", seen, 0);
    rd(6, v); chk("R9 register kept", v, 32'h1234);

    // R8 disabled input ignored
    seen = 0;
    @(negedge clk) cap_in[3] = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (cap_evt != 0) seen++;
    end
    chk("R8 disabled no strobe", seen, 0);
    rd(7, v); chk("R8 disabled register", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule